// File: doc/BRIEF.md
# Card Socket Event Latch

This block records changes in the status of a removable-card slot and raises an interrupt. It watches four raw status lines: a power-cycle indication, two card-detect lines and a card status-change line. Each line goes through a synchronizer and is compared with its previously sampled value. A qualifying change sets a sticky event bit. Software reads the four event bits through a 32-bit read port. It clears a bit by writing a 1 to it, and it can set bits through a separate force-event strobe.

Each event bit has its own interrupt enable. The registered interrupt output is high while any enabled event bit is set. A synchronous bus reset and an asynchronous global reset clear the bits under different rules. When the card-side reset is released, any status that is still active is reported again.

Top module: `sock_evt_latch`

## Requirements
- R1: Read bits 31..4 are always 0. Writes and forces to bits 31..4 have no effect on any readable bit.
- R2: Event bit 3 sets when the synchronized power-cycle status (stat_i[3]) changes in either direction.
- R3: Event bit 2 sets when card-detect 2 (stat_i[2]) changes in either direction. Event bit 1 does the same for card-detect 1 (stat_i[1]).
- R4: Event bit 0 follows the status-change line stat_i[0]. With card16_i = 0 it sets only on a 0-to-1 change. With card16_i = 1 it sets on both changes.
- R5: A write with wr_en_i clears every event bit whose wr_data_i bit is 1. Event bits whose wr_data_i bit is 0 keep their value.
- R6: A force strobe with force_en_i sets every event bit whose force_data_i bit (3..0) is 1.
- R7: A bus reset cycle (bus_rst_i = 1) clears event bits 3..1. It clears bit 0 only when pm_en_i = 0; with pm_en_i = 1, bit 0 keeps its value.
- R8: A global reset (rst_ni = 0) clears all event bits and the interrupt output.
- R9: When card_rst_i falls from 1 to 0, the block sets event bits 2..0 for each of stat_i[2..0] that is 1 at that moment. The bits set on the clock edge at which card_rst_i is first seen low.
- R10: irq_o is a register. On each clock edge it loads 1 when some event bit and its ien_i bit are both 1, and loads 0 otherwise.
- R11: When a set from hardware or from the force strobe meets a write-1-to-clear on the same bit in the same cycle, the bit ends up set.
- R12: Status lines pass through a two-flop synchronizer, so a change first shows as an event on the third clock edge after it is applied. Neither reset creates an event from status lines that hold steady across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global reset, asynchronous, active low |
| bus_rst_i | input | 1 | Bus reset, synchronous, active high |
| pm_en_i | input | 1 | Power management enable; bit 0 survives bus reset when set |
| card_rst_i | input | 1 | Card-side reset, active high |
| card16_i | input | 1 | Card type: 1 = 16-bit (both edges), 0 = 32-bit (rising edge) |
| stat_i | input | 4 | Raw status: [3] power cycle, [2] detect 2, [1] detect 1, [0] status change |
| wr_en_i | input | 1 | Write-1-to-clear strobe |
| wr_data_i | input | 32 | Write-1-to-clear data |
| force_en_i | input | 1 | Force-event strobe |
| force_data_i | input | 32 | Force-event data |
| ien_i | input | 4 | Per-bit interrupt enable |
| rd_data_o | output | 32 | Event register read value |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and two synchronizer stages. With these values, a status change shows as an event exactly three edges after it is applied, and the bench samples at that edge and at the edge before it. The 32-bit width lets the bench drive writes and forces that set every reserved bit and confirm that none of them reaches the read port. The bench holds the status lines asserted across both resets to confirm that neither reset creates a spurious event.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;
  localparam int EVT_N   = 4;
  localparam int EVT_PWR = 3;
  localparam int EVT_CD2 = 2;
  localparam int EVT_CD1 = 1;
  localparam int EVT_STS = 0;
endpackage

// File: rtl/sock_evt_sync.sv
module sock_evt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else if (s == 0) pipe_q[s] <= d_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sock_evt_detect.sv
module sock_evt_detect
  import sock_evt_pkg::*;
#(
  parameter int ARM_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             card16_i,
  input  logic             card_rst_i,
  input  logic [EVT_N-1:0] cur_i,
  output logic [EVT_N-1:0] set_o
);
  localparam int CNT_W = $clog2(ARM_CNT + 1);

  logic [CNT_W-1:0] arm_cnt_q;
  logic             armed;
  logic [EVT_N-1:0] prev_q;
  logic [EVT_N-1:0] edge_set;
  logic [EVT_N-1:0] rel_set;
  logic             card_rst_q;
  logic             rel;

  assign armed = (arm_cnt_q == CNT_W'(ARM_CNT));

  // hold off detection until the synchronizer carries real input values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_cnt_q <= '0;
    else if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      card_rst_q <= 1'b0;
    end else begin
      prev_q     <= cur_i;
      card_rst_q <= card_rst_i;
    end
  end

  generate
    for (genvar i = 0; i < EVT_N; i++) begin : g_edge
      if (i == EVT_STS) begin : g_sts
        assign edge_set[i] = card16_i ? (cur_i[i] ^ prev_q[i]) : (cur_i[i] & ~prev_q[i]);
      end else begin : g_any
        assign edge_set[i] = cur_i[i] ^ prev_q[i];
      end
      if (i == EVT_PWR) begin : g_norel
        assign rel_set[i] = 1'b0;
      end else begin : g_rel
        assign rel_set[i] = rel & cur_i[i];
      end
    end
  endgenerate

  assign rel   = card_rst_q & ~card_rst_i;
  assign set_o = (armed && !bus_rst_i) ? (edge_set | rel_set) : '0;

  assert_rise_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card16_i && prev_q[EVT_STS] && !cur_i[EVT_STS]) |-> !set_o[EVT_STS]);

  assert_unarmed_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed || bus_rst_i) |-> (set_o == '0));
endmodule

// File: rtl/sock_evt_reg.sv
module sock_evt_reg
  import sock_evt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              pm_en_i,
  input  logic [EVT_N-1:0]  hw_set_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              force_en_i,
  input  logic [DATA_W-1:0] force_data_i,
  output logic [EVT_N-1:0]  evt_o
);
  logic [EVT_N-1:0] evt_q;
  logic [EVT_N-1:0] set_all;
  logic [EVT_N-1:0] clr;
  logic [EVT_N-1:0] evt_d;

  assign set_all = hw_set_i | (force_en_i ? force_data_i[EVT_N-1:0] : '0);
  assign clr     = wr_en_i ? wr_data_i[EVT_N-1:0] : '0;

  always_comb begin
    evt_d = (evt_q & ~clr) | set_all;  // set beats clear
    if (bus_rst_i) begin
      evt_d[EVT_N-1:1] = '0;
      if (!pm_en_i) evt_d[EVT_STS] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((evt_q & $past(clr & ~set_all)) == '0));

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|set_all) && !bus_rst_i) |=> ((evt_q & $past(set_all)) == $past(set_all)));

  assert_bus_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (evt_q[EVT_N-1:1] == '0));

  assert_pm_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && pm_en_i && evt_q[EVT_STS] && !clr[EVT_STS]) |=> evt_q[EVT_STS]);
endmodule

// File: rtl/sock_evt_latch.sv
module sock_evt_latch
  import sock_evt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              pm_en_i,
  input  logic              card_rst_i,
  input  logic              card16_i,
  input  logic [3:0]        stat_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              force_en_i,
  input  logic [DATA_W-1:0] force_data_i,
  input  logic [3:0]        ien_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int ARM_CNT = SYNC_STAGES + 1;
  localparam int RSVD_W  = DATA_W - EVT_N;

  logic [EVT_N-1:0] stat_sync;
  logic [EVT_N-1:0] hw_set;
  logic [EVT_N-1:0] evt;
  logic             irq_q;

  sock_evt_sync #(.W(EVT_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stat_i),
    .q_o    (stat_sync)
  );

  sock_evt_detect #(.ARM_CNT(ARM_CNT)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_i  (bus_rst_i),
    .card16_i   (card16_i),
    .card_rst_i (card_rst_i),
    .cur_i      (stat_sync),
    .set_o      (hw_set)
  );

  sock_evt_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_rst_i    (bus_rst_i),
    .pm_en_i      (pm_en_i),
    .hw_set_i     (hw_set),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .force_en_i   (force_en_i),
    .force_data_i (force_data_i),
    .evt_o        (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |(evt & ien_i);
  end

  assign rd_data_o = {{RSVD_W{1'b0}}, evt};
  assign irq_o     = irq_q;

  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(ien_i) != '0));
endmodule

// File: tb/sock_evt_latch_test.sv
module sock_evt_latch_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_i = 1'b0;
  logic        pm_en_i = 1'b0;
  logic        card_rst_i = 1'b0;
  logic        card16_i = 1'b0;
  logic [3:0]  stat_i = 4'b0110;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        force_en_i = 1'b0;
  logic [31:0] force_data_i = '0;
  logic [3:0]  ien_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_rd_q [$];
  logic        exp_irq_q [$];
  bit          use_irq_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  sock_evt_latch uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst_i), .pm_en_i(pm_en_i),
    .card_rst_i(card_rst_i), .card16_i(card16_i), .stat_i(stat_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .force_en_i(force_en_i),
    .force_data_i(force_data_i), .ien_i(ien_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // monitor: compares at the falling edge after each push
  always @(negedge clk) begin
    if (exp_rd_q.size() > 0) begin
      logic [31:0] erd;
      logic        eirq;
      bit          ui;
      string       t;
      erd  = exp_rd_q.pop_front();
      eirq = exp_irq_q.pop_front();
      ui   = use_irq_q.pop_front();
      t    = tag_q.pop_front();
      checks++;
      if (rd_data_o !== erd || (ui && irq_o !== eirq)) begin
        failures++;
        $display("FAIL %s rd=%h exp=%h irq=%b exp_irq=%b", t, rd_data_o, erd, irq_o, eirq);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // expectation applies after the next rising edge
  task automatic chk(logic [31:0] rd, string t);
    exp_rd_q.push_back(rd); exp_irq_q.push_back(1'b0); use_irq_q.push_back(1'b0); tag_q.push_back(t);
    step(1);
  endtask

  task automatic chk_irq(logic [31:0] rd, logic irq, string t);
    exp_rd_q.push_back(rd); exp_irq_q.push_back(irq); use_irq_q.push_back(1'b1); tag_q.push_back(t);
    step(1);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d; step(1); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic frc(logic [31:0] d);
    force_en_i = 1'b1; force_data_i = d; step(1); force_en_i = 1'b0; force_data_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(6);
    // R8 R12: reset state, steady detect lines give no event
    chk_irq(32'h0, 1'b0, "R8 R12 reset state");

    // R12 R3: detect 1 falls, latency three edges
    stat_i = 4'b0100;
    step(1);
    chk(32'h0, "R12 not before third edge");
    chk(32'h2, "R3 R12 detect1 change on third edge");
    wr(32'h2);
    chk(32'h0, "R5 clear bit1");

    // R3: detect 2 both directions
    stat_i = 4'b0000; step(4);
    chk(32'h4, "R3 detect2 fall");
    wr(32'h4);
    stat_i = 4'b0100; step(4);
    chk(32'h4, "R3 detect2 rise");
    wr(32'h4);

    // R2: power cycle both directions
    stat_i = 4'b1100; step(4);
    chk(32'h8, "R2 power rise");
    wr(32'h8);
    stat_i = 4'b0100; step(4);
    chk(32'h8, "R2 power fall");
    wr(32'h8);

    // R4: 32-bit card, rising only
    card16_i = 1'b0;
    stat_i = 4'b0101; step(4);
    chk(32'h1, "R4 rise sets in 32-bit mode");
    wr(32'h1);
    stat_i = 4'b0100; step(4);
    chk(32'h0, "R4 fall ignored in 32-bit mode");
    // R4: 16-bit card, both edges
    card16_i = 1'b1;
    stat_i = 4'b0101; step(4);
    chk(32'h1, "R4 rise sets in 16-bit mode");
    wr(32'h1);
    stat_i = 4'b0100; step(4);
    chk(32'h1, "R4 fall sets in 16-bit mode");
    wr(32'h1);

    // R6 R5
    frc(32'hF);
    chk(32'hF, "R6 force all");
    wr(32'h0);
    chk(32'hF, "R5 zero write keeps bits");
    wr(32'h5);
    chk(32'hA, "R5 partial clear");
    wr(32'hFFFF_FFFF);
    chk(32'h0, "R5 clear all");

    // R1: reserved bits
    frc(32'hFFFF_FFF0);
    chk(32'h0, "R1 reserved force ignored");
    frc(32'hFFFF_FFFF);
    chk(32'hF, "R1 R6 only low bits readable");
    wr(32'hFFFF_FFF0);
    chk(32'hF, "R1 reserved write ignored");
    wr(32'hF);

    // R10: registered irq follows enables
    frc(32'h4);
    chk_irq(32'h4, 1'b0, "R10 masked irq low");
    ien_i = 4'h4;
    chk_irq(32'h4, 1'b1, "R10 enabled irq one edge later");
    ien_i = 4'h2;
    chk_irq(32'h4, 1'b0, "R10 other bit enabled only");
    ien_i = 4'h0;
    wr(32'h4);

    // R11: force and clear on the same bit
    force_en_i = 1'b1; force_data_i = 32'h2;
    wr_en_i = 1'b1; wr_data_i = 32'h2;
    step(1);
    force_en_i = 1'b0; force_data_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    chk(32'h2, "R11 set wins over clear");
    wr(32'h2);

    // R7: bus reset with and without power management
    frc(32'hF);
    pm_en_i = 1'b1; bus_rst_i = 1'b1; step(1); bus_rst_i = 1'b0;
    chk(32'h1, "R7 pm enabled keeps bit0");
    frc(32'hF);
    pm_en_i = 1'b0; bus_rst_i = 1'b1; step(1); bus_rst_i = 1'b0;
    step(3);
    chk(32'h0, "R7 R12 pm disabled clears all, no spurious");

    // R9: card reset release
    stat_i = 4'b0101; step(4);
    wr(32'hF);
    chk(32'h0, "R9 cleared before card reset");
    card_rst_i = 1'b1; step(3);
    card_rst_i = 1'b0;
    chk(32'h5, "R9 re-report on release");
    wr(32'hF);

    // R8 R12: global reset mid-run
    frc(32'hF);
    ien_i = 4'hF; step(2);
    rst_ni = 1'b0;
    chk_irq(32'h0, 1'b0, "R8 global reset clears");
    step(2);
    rst_ni = 1'b1;
    step(6);
    chk_irq(32'h0, 1'b0, "R8 R12 no event after release");

    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule